// File: doc/BRIEF.md
# Correlator Timebase and Status Controller

This block provides the timing backbone of a multi-channel satellite-navigation correlator. It runs two independent programmable down-counters. The measurement counter produces a one-clock `tic_o` strobe, which the channels use to latch their measurements. The accumulation counter produces a one-clock `acc_irq_o` strobe, and only does so once software has enabled it.

Each strobe sets a sticky status flag. Software clears these flags explicitly through a dedicated command register. A per-channel new-data mask records which channels have dumped fresh accumulator results. Reading that mask clears it.

Software reaches everything through a simple word-addressed register bus. This includes:
- the period registers,
- the live counter values,
- the status and new-data words,
- a fixed identification word,
- a software-reset control that drives `sw_reset_o` and holds it until written back to zero.

A read request returns its data one clock later.

Top module: `tbc_timebase`

## Requirements
- R1: The measurement counter decrements by one each clock. On the clock where it reads zero, `tic_o` is high for exactly that clock and the counter reloads the measurement period register (word address 0xF1). A period value N therefore gives one strobe every N+1 clocks, and the live count reads at word address 0xE2.
- R2: The accumulation counter behaves the same way, using its period register (0xF2) and its live count (0xE3), but only while bit 0 of the accumulation control register (0xF3) is 1. While that bit is 0, the counter holds the programmed period value and `acc_irq_o` stays low.
- R3: A new period written while a count is in progress does not shorten or lengthen that count. It first takes effect at the next reload.
- R4: STATUS (0xE0) bit 0 is set on the clock after a `tic_o` strobe, and bit 1 is set on the clock after an `acc_irq_o` strobe. Reading STATUS leaves both bits unchanged.
- R5: Writing to the clear register (0xE4) clears each STATUS bit whose matching write-data bit is 1. If a strobe coincides with the clear, its flag stays set.
- R6: NEW_DATA (0xE1) bit i is set on the clock after `chan_dump_i[i]` is high. A read returns the mask and then clears it. A dump arriving in the same clock as that read sets its bit again.
- R7: Bit 0 of the software-reset register (0xF0) drives `sw_reset_o`. The output holds its value until that register is written again.
- R8: Reading the identification register (0xEF) returns the HW_ID parameter, and writes to it have no effect.
- R9: After reset:
  - both period registers hold their reset parameters;
  - the accumulation counter is disabled and reads its reset period;
  - STATUS, NEW_DATA and `sw_reset_o` are 0.
- R10: `bus_rdata_o` and `bus_rvalid_o` are valid on the clock after a read request. An unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, one clock after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| chan_dump_i | input | N_CH | Per-channel dump pulses |
| tic_o | output | 1 | Measurement strobe |
| acc_irq_o | output | 1 | Accumulation-interrupt strobe |
| sw_reset_o | output | 1 | Software reset level |

## Verification
Two pairs of functions can land in the same clock:
- a counter strobe setting a STATUS flag while a clear command is removing it;
- a channel dump setting a NEW_DATA bit while a read is clearing it.

The bench provokes the first pair by waiting for the strobe to appear and launching the clear write in that same cycle. It provokes the second by raising a dump pulse together with the read request. It then judges the outcome by reading back the affected word: the flag must still be set, and the new channel bit must appear on the following read even though the coincident read returned only the older bits.

// File: rtl/tbc_pkg.sv
// Shared constants for the correlator timebase controller.
// Assumes a fixed 8-bit word address space on the register bus.
package tbc_pkg;
    localparam int ADDR_W  = 8;
    localparam int N_FLAGS = 2;
    localparam int FLAG_TIC = 0;
    localparam int FLAG_ACC = 1;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_STATUS  = 8'hE0;
    localparam addr_t A_NEWDATA = 8'hE1;
    localparam addr_t A_TICCNT  = 8'hE2;
    localparam addr_t A_ACCCNT  = 8'hE3;
    localparam addr_t A_CLEAR   = 8'hE4;
    localparam addr_t A_HWID    = 8'hEF;
    localparam addr_t A_SWRST   = 8'hF0;
    localparam addr_t A_TICPER  = 8'hF1;
    localparam addr_t A_ACCPER  = 8'hF2;
    localparam addr_t A_ACCCTL  = 8'hF3;
endpackage

// File: rtl/tbc_downcounter.sv
// Programmable down-counter timebase.
// Counts down once per clock while enabled.
// At zero it emits a one-clock strobe and reloads period_i.
// While disabled it holds period_i so that it starts a full count when enabled.
// Assumes period_i is stable except when the register bus writes it.
module tbc_downcounter #(
    parameter int CNT_W = 24,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             strobe_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero  = (cnt_q == '0);
    assign strobe_o = en_i && at_zero;
    assign count_o  = cnt_q;

    // Count down, reload on expiry, hold the period while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RST_VAL;
        else if (!en_i || at_zero)
            cnt_q <= period_i;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // R1
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> (cnt_q == $past(period_i)));
    // R1
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R1
    one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && period_i != '0) |=> !strobe_o);
endmodule

// File: rtl/tbc_flags.sv
// Bank of sticky flags.
// A set request wins over a clear request in the same clock, so no event is lost.
// Assumes set and clear are single-clock requests from neighbouring logic.
module tbc_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;
    assign flags_o = flags_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold each flag until cleared; a coincident set keeps it high.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (set_i[i])
                flags_q[i] <= 1'b1;
            else if (clr_i[i])
                flags_q[i] <= 1'b0;
        end

        // R5
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_q[i]);
        // R4
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_i[i]) |=> flags_q[i]);
        // R5
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flags_q[i]);
    end
endmodule

// File: rtl/tbc_regfile.sv
// Register bus front end.
// Decodes word-addressed reads and writes and holds the period, enable and
// software-reset registers.
// Produces single-clock clear commands for the status and new-data flags.
// Returns read data registered one clock after the request.
// Assumes at most one request per clock.
module tbc_regfile
    import tbc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int N_CH   = 12,
    parameter logic [CNT_W-1:0]  TIC_RST = '0,
    parameter logic [CNT_W-1:0]  ACC_RST = '0,
    parameter logic [DATA_W-1:0] HW_ID   = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid_i,
    input  logic               bus_write_i,
    input  addr_t              bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               bus_rvalid_o,
    input  logic [N_FLAGS-1:0] status_i,
    input  logic [N_CH-1:0]    newdata_i,
    input  logic [CNT_W-1:0]   tic_cnt_i,
    input  logic [CNT_W-1:0]   acc_cnt_i,
    output logic [CNT_W-1:0]   tic_period_o,
    output logic [CNT_W-1:0]   acc_period_o,
    output logic               acc_en_o,
    output logic               sw_reset_o,
    output logic [N_FLAGS-1:0] clr_status_o,
    output logic               rd_newdata_o
);
    logic              wr_en, rd_en;
    logic [CNT_W-1:0]  tic_per_q, acc_per_q;
    logic              acc_en_q, swrst_q;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic              rvalid_q;

    assign wr_en = bus_valid_i && bus_write_i;
    assign rd_en = bus_valid_i && !bus_write_i;

    assign tic_period_o = tic_per_q;
    assign acc_period_o = acc_per_q;
    assign acc_en_o     = acc_en_q;
    assign sw_reset_o   = swrst_q;
    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = rvalid_q;

    // Clear command for the status flags: one clock, masked by write data.
    assign clr_status_o = (wr_en && bus_addr_i == A_CLEAR) ? bus_wdata_i[N_FLAGS-1:0] : '0;
    // Read-to-clear for the new-data mask.
    assign rd_newdata_o = rd_en && (bus_addr_i == A_NEWDATA);

    // Writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tic_per_q <= TIC_RST;
            acc_per_q <= ACC_RST;
            acc_en_q  <= 1'b0;
            swrst_q   <= 1'b0;
        end else if (wr_en) begin
            case (bus_addr_i)
                A_TICPER: tic_per_q <= bus_wdata_i[CNT_W-1:0];
                A_ACCPER: acc_per_q <= bus_wdata_i[CNT_W-1:0];
                A_ACCCTL: acc_en_q  <= bus_wdata_i[0];
                A_SWRST:  swrst_q   <= bus_wdata_i[0];
                default: ;
            endcase
        end
    end

    // Select the word addressed by a read.
    always_comb begin
        case (bus_addr_i)
            A_STATUS:  rd_mux = DATA_W'(status_i);
            A_NEWDATA: rd_mux = DATA_W'(newdata_i);
            A_TICCNT:  rd_mux = DATA_W'(tic_cnt_i);
            A_ACCCNT:  rd_mux = DATA_W'(acc_cnt_i);
            A_HWID:    rd_mux = HW_ID;
            A_SWRST:   rd_mux = DATA_W'(swrst_q);
            A_TICPER:  rd_mux = DATA_W'(tic_per_q);
            A_ACCPER:  rd_mux = DATA_W'(acc_per_q);
            A_ACCCTL:  rd_mux = DATA_W'(acc_en_q);
            default:   rd_mux = '0;
        endcase
    end

    // Register read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en;
            if (rd_en)
                rdata_q <= rd_mux;
        end
    end

    // R7
    swrst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr_i == A_SWRST) |=> $stable(sw_reset_o));
    // R10
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid_o);
endmodule

// File: rtl/tbc_timebase.sv
// Correlator timebase and status controller top.
// Two down-counter timebases drive the measurement strobe and the
// accumulation interrupt.
// Sticky status flags record each strobe; a new-data mask collects channel dumps.
// All state is reachable through the word-addressed register bus.
// Assumes chan_dump_i pulses are synchronous to clk.
module tbc_timebase
    import tbc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int N_CH   = 12,
    parameter logic [CNT_W-1:0]  TIC_RST = CNT_W'(20),
    parameter logic [CNT_W-1:0]  ACC_RST = CNT_W'(10),
    parameter logic [DATA_W-1:0] HW_ID   = DATA_W'(32'h5A17_0C01)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    input  logic [N_CH-1:0]   chan_dump_i,
    output logic              tic_o,
    output logic              acc_irq_o,
    output logic              sw_reset_o
);
    logic [CNT_W-1:0]   tic_period, acc_period, tic_cnt, acc_cnt;
    logic               acc_en, rd_newdata;
    logic [N_FLAGS-1:0] status, clr_status, status_set;
    logic [N_CH-1:0]    newdata;

    tbc_regfile #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .N_CH(N_CH),
        .TIC_RST(TIC_RST), .ACC_RST(ACC_RST), .HW_ID(HW_ID)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o),
        .status_i(status), .newdata_i(newdata),
        .tic_cnt_i(tic_cnt), .acc_cnt_i(acc_cnt),
        .tic_period_o(tic_period), .acc_period_o(acc_period),
        .acc_en_o(acc_en), .sw_reset_o(sw_reset_o),
        .clr_status_o(clr_status), .rd_newdata_o(rd_newdata)
    );

    tbc_downcounter #(.CNT_W(CNT_W), .RST_VAL(TIC_RST)) tic_cnt_i (
        .clk(clk), .rst_n(rst_n), .en_i(1'b1), .period_i(tic_period),
        .count_o(tic_cnt), .strobe_o(tic_o)
    );

    tbc_downcounter #(.CNT_W(CNT_W), .RST_VAL(ACC_RST)) acc_cnt_i (
        .clk(clk), .rst_n(rst_n), .en_i(acc_en), .period_i(acc_period),
        .count_o(acc_cnt), .strobe_o(acc_irq_o)
    );

    always_comb begin
        status_set           = '0;
        status_set[FLAG_TIC] = tic_o;
        status_set[FLAG_ACC] = acc_irq_o;
    end

    tbc_flags #(.N(N_FLAGS)) status_i (
        .clk(clk), .rst_n(rst_n), .set_i(status_set),
        .clr_i(clr_status), .flags_o(status)
    );

    tbc_flags #(.N(N_CH)) newdata_i (
        .clk(clk), .rst_n(rst_n), .set_i(chan_dump_i),
        .clr_i({N_CH{rd_newdata}}), .flags_o(newdata)
    );

    // R2
    acc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> !acc_irq_o);
    // R6
    dump_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_newdata && chan_dump_i != '0) |=> (newdata == $past(chan_dump_i)));
endmodule

// File: tb/tbc_timebase_tb_top.sv
`timescale 1ns/1ps
module tbc_timebase_tb_top;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int N_CH   = 8;
    localparam logic [CNT_W-1:0]  TIC_RST = 16'd20;
    localparam logic [CNT_W-1:0]  ACC_RST = 16'd10;
    localparam logic [DATA_W-1:0] HW_ID   = 32'h7B3C_0001;

    localparam logic [7:0] A_STATUS = 8'hE0, A_NEWDATA = 8'hE1, A_TICCNT = 8'hE2,
                           A_ACCCNT = 8'hE3, A_CLEAR = 8'hE4, A_HWID = 8'hEF,
                           A_SWRST = 8'hF0, A_TICPER = 8'hF1, A_ACCPER = 8'hF2,
                           A_ACCCTL = 8'hF3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
    logic              bus_rvalid;
    logic [N_CH-1:0]   chan_dump = '0;
    logic              tic, acc_irq, sw_reset;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tbc_timebase #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .N_CH(N_CH),
        .TIC_RST(TIC_RST), .ACC_RST(ACC_RST), .HW_ID(HW_ID)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
        .chan_dump_i(chan_dump),
        .tic_o(tic), .acc_irq_o(acc_irq), .sw_reset_o(sw_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Caller is at a negedge; returns at the next negedge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        if (bus_rvalid !== 1'b1) chk("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
    endtask

    // Advance negedges until the strobe is seen; returns the clocks waited.
    task automatic wait_tic(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tic && n < 2000);
        if (!tic) chk("R1 tic timeout", 32'd0, 32'd1);
    endtask

    task automatic wait_acc(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!acc_irq && n < 2000);
        if (!acc_irq) chk("R2 acc timeout", 32'd0, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(A_STATUS, d);  chk("R9 status", d, 32'd0);
        bus_rd(A_NEWDATA, d); chk("R9 newdata", d, 32'd0);
        bus_rd(A_ACCCNT, d);  chk("R9 acc count", d, 32'(ACC_RST));
        bus_rd(A_TICPER, d);  chk("R9 tic period", d, 32'(TIC_RST));
        chk("R9 sw_reset", {31'b0, sw_reset}, 32'd0);
        chk("R9 acc_irq", {31'b0, acc_irq}, 32'd0);
    endtask

    task automatic t_tic_period();
        logic [31:0] d;
        int n;
        bus_wr(A_TICPER, 32'd4);
        wait_tic(n);
        @(negedge clk);
        chk("R1 one clock wide", {31'b0, tic}, 32'd0);
        wait_tic(n);
        chk("R1 interval N+1", 32'(n + 1), 32'd5);
        @(negedge clk);
        bus_rd(A_TICCNT, d); chk("R1 live count after reload", d, 32'd4);
        bus_rd(A_TICCNT, d); chk("R1 live count decrement", d, 32'd3);
    endtask

    task automatic t_period_change();
        int n;
        wait_tic(n);
        @(negedge clk);
        bus_wr(A_TICPER, 32'd9);
        wait_tic(n);
        chk("R3 old period finishes", 32'(n), 32'd3);
        wait_tic(n);
        chk("R3 new period at reload", 32'(n), 32'd10);
    endtask

    task automatic t_status_tic();
        logic [31:0] d;
        int n;
        bus_wr(A_TICPER, 32'd300);
        wait_tic(n);
        @(negedge clk);
        bus_rd(A_STATUS, d); chk("R4 tic flag set", d & 32'd1, 32'd1);
        bus_rd(A_STATUS, d); chk("R4 flag survives read", d & 32'd1, 32'd1);
        bus_wr(A_CLEAR, 32'd1);
        bus_rd(A_STATUS, d); chk("R5 tic flag cleared", d & 32'd1, 32'd0);
        wait_tic(n);
        bus_wr(A_CLEAR, 32'd1);
        bus_rd(A_STATUS, d); chk("R5 coincident clear keeps tic", d & 32'd1, 32'd1);
        bus_wr(A_CLEAR, 32'd1);
    endtask

    task automatic t_acc();
        logic [31:0] d;
        bit seen;
        int n;
        bus_wr(A_ACCPER, 32'd6);
        @(negedge clk);
        bus_rd(A_ACCCNT, d); chk("R2 disabled holds period", d, 32'd6);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (acc_irq) seen = 1;
        end
        chk("R2 no strobe while disabled", {31'b0, seen}, 32'd0);
        bus_rd(A_STATUS, d); chk("R2 no acc flag while disabled", d & 32'd2, 32'd0);
        bus_wr(A_ACCCTL, 32'd1);
        wait_acc(n);
        wait_acc(n);
        chk("R2 acc interval", 32'(n), 32'd7);
        @(negedge clk);
        bus_rd(A_STATUS, d); chk("R4 acc flag set", d & 32'd2, 32'd2);
        wait_acc(n);
        bus_wr(A_CLEAR, 32'd2);
        bus_rd(A_STATUS, d); chk("R5 coincident clear keeps acc", d & 32'd2, 32'd2);
        bus_wr(A_ACCCTL, 32'd0);
        wait_tic(n);
        @(negedge clk);
        bus_wr(A_CLEAR, 32'd1);
        bus_rd(A_STATUS, d); chk("R5 mask clears only bit 0", d & 32'd3, 32'd2);
        bus_wr(A_CLEAR, 32'd2);
        bus_rd(A_STATUS, d); chk("R5 mask clears bit 1", d & 32'd3, 32'd0);
    endtask

    task automatic t_newdata();
        logic [31:0] d;
        chan_dump = 8'h08;
        @(negedge clk);
        chan_dump = '0;
        bus_rd(A_NEWDATA, d); chk("R6 dump sets bit", d, 32'h08);
        bus_rd(A_NEWDATA, d); chk("R6 read clears", d, 32'h00);
        chan_dump = 8'h02;
        @(negedge clk);
        chan_dump = 8'h20;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = A_NEWDATA;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; chan_dump = '0;
        chk("R6 coincident read returns old", bus_rdata, 32'h02);
        bus_rd(A_NEWDATA, d); chk("R6 coincident dump kept", d, 32'h20);
    endtask

    task automatic t_swrst();
        logic [31:0] d;
        bus_wr(A_SWRST, 32'd1);
        chk("R7 sw_reset set", {31'b0, sw_reset}, 32'd1);
        repeat (5) @(negedge clk);
        bus_wr(A_ACCPER, 32'd6);
        chk("R7 sw_reset held", {31'b0, sw_reset}, 32'd1);
        bus_wr(A_SWRST, 32'd0);
        chk("R7 sw_reset released", {31'b0, sw_reset}, 32'd0);
        bus_wr(A_HWID, 32'h0);
        bus_rd(A_HWID, d); chk("R8 hw id", d, HW_ID);
        bus_rd(8'h10, d); chk("R10 unmapped reads zero", d, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tic_period();
        t_period_change();
        t_status_tic();
        t_acc();
        t_newdata();
        t_swrst();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule